// File: doc/BRIEF.md
# Warp Lane Shuffle Unit

This unit swaps register values between the 32 lanes of a SIMD group in one pass. Every lane works out a source lane from four inputs: its own lane number, a two-bit addressing mode, a five-bit index operand and a thirteen-bit control word. The control word splits the group into equal segments and sets a clamp that bounds each segment's usable range. The lane then takes the value of its source lane and reports through a predicate whether that source was valid.

There are four addressing modes. Indexed mode picks a fixed position inside each segment, which serves broadcast and arbitrary gather. Up mode and down mode move data by a fixed distance, toward higher lanes or toward lower lanes, as scan steps need. Butterfly mode exchanges across an XOR distance, as tree reductions and quad derivatives need. When a source lies outside the bound, the lane keeps its own value and its predicate is low.

Inputs are taken on an `in_valid_i` pulse. Results and predicates appear on registers one clock later, marked by `out_valid_o`.

Top module: `warp_shuffle`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o`, every bit of `lane_pred_o` and every bit of `lane_data_o` are 0.
- R2: `out_valid_o` is high exactly one cycle after a cycle in which `in_valid_i` was high. Results and predicates change only on that edge and otherwise hold.
- R3: The segment mask is `ctrl_i[12:8]` and the clamp is `ctrl_i[4:0]`. Bits `ctrl_i[7:5]` have no effect on any output. For lane i, the lowest lane of its segment is lo = i AND mask, and the highest usable lane is hi = lo + (clamp AND NOT mask).
- R4: Mode 2'b00 (indexed): the source is j = lo + (index AND NOT mask), and it is valid when j ≤ hi.
- R5: Mode 2'b01 (up): the source is j = i − index, and it is valid when j ≥ lo. A j below 0 is never valid.
- R6: Mode 2'b10 (down): the source is j = i + index, and it is valid when j ≤ hi. A j above 31 is never valid.
- R7: Mode 2'b11 (butterfly): the source is j = i XOR index, and it is valid when j ≤ hi.
- R8: A lane with a valid source outputs lane j's input value and predicate 1. A lane with an invalid source outputs its own input value and predicate 0. Lane k occupies `lane_data_i[32k+31:32k]`, and predicate k is bit k. A result taken from an inactive source lane is unspecified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid this cycle |
| mode_i | input | 2 | Addressing mode |
| index_i | input | 5 | Index or distance operand |
| ctrl_i | input | 13 | Segment mask [12:8], clamp [4:0] |
| lane_active_i | input | 32 | Active flag per lane |
| lane_data_i | input | 1024 | Packed 32-bit value per lane |
| out_valid_o | output | 1 | Results valid |
| lane_data_o | output | 1024 | Packed result per lane |
| lane_pred_o | output | 32 | In-range predicate per lane |

## Verification
Each lane's source calculation is separate logic, so a fault in one lane's bound or adder shows at the outputs one cycle after the request. It appears either as a wrong predicate bit or as another lane's value in that lane's slot. The result table covers every mode with one, two, four and eight segments, with sources both inside and outside the bound. Together these expose a wrong segment floor, a wrong clamp or a wrong fallback within a single transaction. A fault in the output register shows as held data that changes with no request, or as a valid flag that is late or stays high. These faults are checked on the cycle right after each stimulus.

// File: rtl/warp_shuffle_pkg.sv
package warp_shuffle_pkg;
  typedef enum logic [1:0] {
    SHF_IDX  = 2'b00,
    SHF_UP   = 2'b01,
    SHF_DOWN = 2'b10,
    SHF_BFLY = 2'b11
  } shf_mode_e;
endpackage

// File: rtl/shf_src_calc.sv
module shf_src_calc
  import warp_shuffle_pkg::*;
#(
  parameter int LANE_W  = 5,
  parameter int LANE_ID = 0
) (
  input  logic [1:0]        mode_i,
  input  logic [LANE_W-1:0] index_i,
  input  logic [LANE_W-1:0] mask_i,
  input  logic [LANE_W-1:0] clamp_i,
  output logic [LANE_W-1:0] src_o,
  output logic              ok_o
);
  localparam logic [LANE_W-1:0] MY_ID = LANE_W'(LANE_ID);

  logic [LANE_W-1:0] seg_lo, seg_hi;
  logic [LANE_W:0]   cand;
  logic              ok;

  assign seg_lo = MY_ID & mask_i;
  assign seg_hi = seg_lo | (clamp_i & ~mask_i);

  // one extra bit so underflow/overflow are visible
  always_comb begin
    cand = '0;
    ok   = 1'b0;
    unique case (shf_mode_e'(mode_i))
      SHF_IDX: begin
        cand = {1'b0, seg_lo} + {1'b0, index_i & ~mask_i};
        ok   = cand <= {1'b0, seg_hi};
      end
      SHF_UP: begin
        cand = {1'b0, MY_ID} - {1'b0, index_i};
        ok   = !cand[LANE_W] && (cand >= {1'b0, seg_lo});
      end
      SHF_DOWN: begin
        cand = {1'b0, MY_ID} + {1'b0, index_i};
        ok   = cand <= {1'b0, seg_hi};
      end
      SHF_BFLY: begin
        cand = {1'b0, MY_ID ^ index_i};
        ok   = cand <= {1'b0, seg_hi};
      end
      default: begin
        cand = '0;
        ok   = 1'b0;
      end
    endcase
  end

  assign ok_o  = ok;
  assign src_o = ok ? cand[LANE_W-1:0] : MY_ID;
endmodule

// File: rtl/shf_lane_mux.sv
module shf_lane_mux #(
  parameter int NUM_LANES = 32,
  parameter int DATA_W    = 32,
  parameter int LANE_W    = $clog2(NUM_LANES)
) (
  input  logic [NUM_LANES*DATA_W-1:0] data_i,
  input  logic [NUM_LANES-1:0]        active_i,
  input  logic [LANE_W-1:0]           sel_i,
  input  logic                        ok_i,
  output logic [DATA_W-1:0]           data_o
);
  logic [DATA_W-1:0] picked;

  assign picked = data_i[sel_i*DATA_W +: DATA_W];
  // inactive remote source: undefined data, drive zero to avoid toggling
  assign data_o = (ok_i && !active_i[sel_i]) ? '0 : picked;
endmodule

// File: rtl/warp_shuffle.sv
module warp_shuffle
  import warp_shuffle_pkg::*;
#(
  parameter int NUM_LANES = 32,
  parameter int DATA_W    = 32,
  parameter int MASK_LSB  = 8,
  parameter int LANE_W    = $clog2(NUM_LANES),
  parameter int CTRL_W    = MASK_LSB + LANE_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  input  logic [1:0]                  mode_i,
  input  logic [LANE_W-1:0]           index_i,
  input  logic [CTRL_W-1:0]           ctrl_i,
  input  logic [NUM_LANES-1:0]        lane_active_i,
  input  logic [NUM_LANES*DATA_W-1:0] lane_data_i,
  output logic                        out_valid_o,
  output logic [NUM_LANES*DATA_W-1:0] lane_data_o,
  output logic [NUM_LANES-1:0]        lane_pred_o
);
  logic [LANE_W-1:0]           mask, clamp;
  logic [NUM_LANES*DATA_W-1:0] res_d;
  logic [NUM_LANES-1:0]        pred_d;

  assign mask  = ctrl_i[MASK_LSB +: LANE_W];
  assign clamp = ctrl_i[LANE_W-1:0];

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    logic [LANE_W-1:0] src;
    logic              ok;

    shf_src_calc #(.LANE_W(LANE_W), .LANE_ID(k)) u_calc (
      .mode_i (mode_i),
      .index_i(index_i),
      .mask_i (mask),
      .clamp_i(clamp),
      .src_o  (src),
      .ok_o   (ok)
    );

    shf_lane_mux #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_mux (
      .data_i  (lane_data_i),
      .active_i(lane_active_i),
      .sel_i   (src),
      .ok_i    (ok),
      .data_o  (res_d[k*DATA_W +: DATA_W])
    );

    assign pred_d[k] = ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      lane_data_o <= '0;
      lane_pred_o <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        lane_data_o <= res_d;
        lane_pred_o <= pred_d;
      end
    end
  end
endmodule

// File: rtl/warp_shuffle_chk.sv
module warp_shuffle_chk
  import warp_shuffle_pkg::*;
#(
  parameter int NUM_LANES = 32,
  parameter int DATA_W    = 32,
  parameter int MASK_LSB  = 8,
  parameter int LANE_W    = $clog2(NUM_LANES),
  parameter int CTRL_W    = MASK_LSB + LANE_W
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        in_valid_i,
  input logic [1:0]                  mode_i,
  input logic [LANE_W-1:0]           index_i,
  input logic [CTRL_W-1:0]           ctrl_i,
  input logic [NUM_LANES*DATA_W-1:0] lane_data_i,
  input logic                        out_valid_o,
  input logic [NUM_LANES*DATA_W-1:0] lane_data_o,
  input logic [NUM_LANES-1:0]        lane_pred_o
);
  logic [LANE_W-1:0] span;
  assign span = ctrl_i[LANE_W-1:0] | ctrl_i[MASK_LSB +: LANE_W];

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(lane_data_o) && $stable(lane_pred_o))); // R2

  AST_UP_ZERO_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == SHF_UP && index_i == '0) |=> (lane_pred_o == '1)); // R5

  AST_IDX_FULL_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == SHF_IDX && span == '1) |=> (lane_pred_o == '1)); // R4

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_fb
    AST_FALLBACK_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> (lane_pred_o[k] ||
        lane_data_o[k*DATA_W +: DATA_W] == $past(lane_data_i[k*DATA_W +: DATA_W]))); // R8
  end
endmodule

bind warp_shuffle warp_shuffle_chk #(
  .NUM_LANES(NUM_LANES), .DATA_W(DATA_W), .MASK_LSB(MASK_LSB)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .mode_i     (mode_i),
  .index_i    (index_i),
  .ctrl_i     (ctrl_i),
  .lane_data_i(lane_data_i),
  .out_valid_o(out_valid_o),
  .lane_data_o(lane_data_o),
  .lane_pred_o(lane_pred_o)
);

// File: tb/warp_shuffle_tb.sv
module warp_shuffle_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int DW = 32;
  localparam int NV = 15;

  // {mode[1:0], index[4:0], ctrl[12:0], active[31:0]}
  localparam logic [51:0] VEC [NV] = '{
    {2'd0, 5'd0,  13'h1C03, 32'hFFFF_FFFF},  // R4 quad bcast 0
    {2'd0, 5'd2,  13'h1C03, 32'hFFFF_FFFF},  // R4
    {2'd0, 5'd5,  13'h001F, 32'hFFFF_FFFF},  // R4 full bcast
    {2'd0, 5'd7,  13'h1C02, 32'hFFFF_FFFF},  // R4 above clamp
    {2'd1, 5'd1,  13'h0000, 32'hFFFF_FFFF},  // R5
    {2'd1, 5'd16, 13'h0000, 32'hFFFF_FFFF},  // R5 negative
    {2'd1, 5'd3,  13'h1800, 32'hFFFF_FFFF},  // R5 octets
    {2'd2, 5'd1,  13'h001F, 32'hFFFF_FFFF},  // R6
    {2'd2, 5'd8,  13'h100F, 32'hFFFF_FFFF},  // R6 halves
    {2'd2, 5'd20, 13'h001F, 32'hFFFF_FFFF},  // R6 past 31
    {2'd3, 5'd16, 13'h001F, 32'hFFFF_FFFF},  // R7
    {2'd3, 5'd1,  13'h1C03, 32'hFFFF_FFFF},  // R7 quad
    {2'd3, 5'd4,  13'h1C03, 32'hFFFF_FFFF},  // R7 leaves quad
    {2'd0, 5'd3,  13'h1CE3, 32'hFFFF_FFFF},  // R3 junk ctrl[7:5]
    {2'd2, 5'd2,  13'h001F, 32'h0F0F_0F0F}   // R8 partial active
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic [1:0]      mode_i = '0;
  logic [4:0]      index_i = '0;
  logic [12:0]     ctrl_i = '0;
  logic [NL-1:0]   lane_active_i = '0;
  logic [NL*DW-1:0] lane_data_i = '0;
  logic            out_valid_o;
  logic [NL*DW-1:0] lane_data_o;
  logic [NL-1:0]   lane_pred_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  warp_shuffle u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .mode_i(mode_i), .index_i(index_i), .ctrl_i(ctrl_i),
    .lane_active_i(lane_active_i), .lane_data_i(lane_data_i),
    .out_valid_o(out_valid_o), .lane_data_o(lane_data_o), .lane_pred_o(lane_pred_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input int mode, input int idx, input int ctrl, input int lane,
                                output int src, output bit ok);
    int m, c, lo, hi;
    m  = (ctrl >> 8) & 31;
    c  = ctrl & 31;
    lo = lane & m;
    hi = lo + (c & ~m & 31);
    case (mode)
      0: begin src = lo + (idx & ~m & 31); ok = src <= hi; end
      1: begin src = lane - idx; ok = src >= lo; end
      2: begin src = lane + idx; ok = src <= hi; end
      default: begin src = lane ^ idx; ok = src <= hi; end
    endcase
    if (!ok) src = lane;
  endfunction

  function automatic logic [DW-1:0] pat(input int v, input int k);
    return {8'(v + 1), 8'(k), 16'hA5C3 ^ 16'(k * 37)};
  endfunction

  task automatic run_vec(input int v);
    logic [NL-1:0] exp_p;
    int src, bad_lane;
    bit ok;
    logic [DW-1:0] got, want;
    string req;
    @(negedge clk_i);
    {mode_i, index_i, ctrl_i, lane_active_i} = VEC[v];
    for (int k = 0; k < NL; k++) lane_data_i[k*DW +: DW] = pat(v, k);
    in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    case (VEC[v][51:50])
      2'd0: req = (v == 13) ? "R3" : "R4";
      2'd1: req = "R5";
      2'd2: req = (v == 14) ? "R8" : "R6";
      default: req = "R7";
    endcase
    exp_p = '0;
    bad_lane = -1;
    got = '0;
    want = '0;
    for (int k = 0; k < NL; k++) begin
      model(int'(VEC[v][51:50]), int'(VEC[v][49:45]), int'(VEC[v][44:32]), k, src, ok);
      exp_p[k] = ok;
      if (VEC[v][src] && bad_lane < 0 && lane_data_o[k*DW +: DW] !== pat(v, src)) begin
        bad_lane = k;
        got = lane_data_o[k*DW +: DW];
        want = pat(v, src);
      end
    end
    check({req, " pred"}, 64'(lane_pred_o), 64'(exp_p));
    check({req, " R8 data"}, 64'(got), 64'(want));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    if (!done) $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [NL*DW-1:0] held_d;
    logic [NL-1:0]    held_p;
    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    check("R1 valid", 64'(out_valid_o), 64'(0));
    check("R1 pred", 64'(lane_pred_o), 64'(0));
    check("R1 data", 64'(|lane_data_o), 64'(0));
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R2 idle valid", 64'(out_valid_o), 64'(0));

    for (int v = 0; v < NV; v++) begin
      run_vec(v);
      check("R2 valid", 64'(out_valid_o), 64'(1));
    end

    // R2 hold while idle
    held_d = lane_data_o;
    held_p = lane_pred_o;
    lane_data_i = ~lane_data_i;
    mode_i = 2'd3;
    index_i = 5'd9;
    @(negedge clk_i);
    check("R2 valid drop", 64'(out_valid_o), 64'(0));
    check("R2 hold pred", 64'(lane_pred_o), 64'(held_p));
    check("R2 hold data", 64'(lane_data_o == held_d), 64'(1));

    // R1 asynchronous reset mid-run
    @(negedge clk_i);
    in_valid_i = 1'b1;
    #1;
    rst_ni = 1'b0;
    #1;
    check("R1 async valid", 64'(out_valid_o), 64'(0));
    check("R1 async pred", 64'(lane_pred_o), 64'(0));
    in_valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule